// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Error Flags

This block is an asynchronous serial receiver. A divider outside the block supplies a clock enable at sixteen times the bit rate. The receiver passes the line through a synchroniser and a glitch filter. It confirms each start bit at mid-bit, then deserialises a frame of 7 or 8 data bits. The frame may also carry an address bit and a parity bit, and it ends with one or two stop bits. The received character goes into a buffer register, together with sticky error flags, a wake flag and a ready flag. A one-cycle read strobe on the buffer clears all of these flags.

Two multiprocessor schemes mark a character as an address. In address-bit mode, an extra bit in the frame carries the mark. In idle-line mode, a character counts as an address when the line has stayed at mark for more than ten bit times before it. Two controls set what reaches the buffer. One can restrict loading to address characters. The other chooses whether a character with an error is loaded or dropped.

Top module: `mp_uart_rx`

## Requirements
- R1: Data arrives least significant bit first. A frame is a start bit (0), the data bits, the address bit (only when `addr_bit_mode_i`=1), the parity bit (only when `par_en_i`=1), then one stop bit (two when `two_stop_i`=1). With `len8_i`=1 the buffer holds all 8 data bits. With `len8_i`=0 it holds 7 data bits right-justified, and bit 7 reads 0.
- R2: A low pulse on `rxd_i` shorter than `GLITCH_CYC` (3) clock cycles starts no reception and changes no output.
- R3: Parity is computed over the data bits and the address bit. With `par_even_i`=0 the total number of ones including the parity bit must be odd, and with `par_even_i`=1 it must be even. A mismatch sets `pe_o`.
- R4: A stop bit sampled low sets `fe_o`.
- R5: `brk_o` is set when every sampled bit after the start bit, including the stop bit, is 0.
- R6: `oe_o` is set when a character is loaded while `rx_ready_o` is still 1.
- R7: In idle-line mode (`addr_bit_mode_i`=0), a character is an address when at least 176 enable ticks of continuous mark (more than 10 bit times) came before its start bit. Otherwise it is data.
- R8: In address-bit mode, the address bit marks the character. `wake_o` takes the mark of the last loaded character: 1 for an address, 0 for data.
- R9: With `wake_only_i`=1, data characters are neither loaded nor flagged ready, and address characters are loaded. With `wake_only_i`=0, every character is loaded.
- R10: With `err_keep_i`=0, a character with a framing, parity or break error updates the error flags only. The buffer and `rx_ready_o` are unchanged. With `err_keep_i`=1, such a character is loaded and flagged ready.
- R11: A cycle with `rd_i`=1 clears `rx_ready_o`, `fe_o`, `pe_o`, `oe_o`, `brk_o` and `wake_o`. `rx_err_o` is 1 exactly when any of `fe_o`, `pe_o`, `oe_o` or `brk_o` is 1.
- R12: A reset or a `soft_rst_i` cycle clears the buffer and every flag, and returns the receiver to idle.
- R13: With the enable tick present on every clock, let k be the first clock edge that samples the falling edge of the start bit on `rxd_i`, and let N be the number of bits after the start bit. The buffer and the flags change after edge k+14+16N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous receiver reset |
| os_tick_i | input | 1 | Oversample enable, 16 per bit |
| rxd_i | input | 1 | Serial input line |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1: even parity, 0: odd parity |
| two_stop_i | input | 1 | Two stop bits |
| addr_bit_mode_i | input | 1 | 1: address-bit mode, 0: idle-line mode |
| wake_only_i | input | 1 | Load address characters only |
| err_keep_i | input | 1 | Load characters that carry errors |
| rd_i | input | 1 | Buffer read strobe, clears flags |
| rx_data_o | output | 8 | Received character |
| rx_ready_o | output | 1 | Character waiting in buffer |
| fe_o | output | 1 | Framing error |
| pe_o | output | 1 | Parity error |
| oe_o | output | 1 | Overrun error |
| brk_o | output | 1 | Break detected |
| rx_err_o | output | 1 | Any error flag set |
| wake_o | output | 1 | Last loaded character was an address |

## Verification
A frame's results land one cycle after the final stop-bit sample, on edge k+14+16N. The synchroniser and filter take four of those cycles, and start confirmation plus mid-bit sampling take the rest. The bench notes k when it drives each start bit and places the expected buffer and flag values in a queue for that exact edge. It compares every output against them at each falling clock edge. A read strobe or soft reset takes effect one edge after the bench drives it, and the bench model applies it on that same edge. The scenario checks sample only after the trailing gap of a frame, when all outputs are settled.

// File: rtl/mp_uart_rx_pkg.sv
`timescale 1ns/1ps
package mp_uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       fe;
    logic       pe;
    logic       brk;
    logic       addr;
  } rx_frame_t;
endpackage

// File: rtl/rx_deglitch.sv
`timescale 1ns/1ps
module rx_deglitch #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic line_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == CW'(GLITCH_CYC - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = filt_q;

  // R2: filtered line only moves towards the synchronised level
  a_r2_flip_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q));
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
  import mp_uart_rx_pkg::*;
#(
  parameter int OS_RATE   = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      tick_i,
  input  logic      line_i,
  input  logic      len8_i,
  input  logic      par_en_i,
  input  logic      par_even_i,
  input  logic      two_stop_i,
  input  logic      addr_mode_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int SCW        = $clog2(OS_RATE);
  localparam int MID        = OS_RATE / 2 - 1;
  localparam int LAST       = OS_RATE - 1;
  localparam int IDLE_TICKS = (IDLE_BITS + 1) * OS_RATE;
  localparam int ICW        = $clog2(IDLE_TICKS + 1);

  rx_state_e      st_q;
  logic [SCW-1:0] sc_q;
  logic [2:0]     bit_q;
  logic [7:0]     sh_q;
  logic           par_q, one_q, fe_q, stop2_q, addr_q;
  logic [ICW-1:0] idle_cnt_q;
  logic           idle_seen_q;
  logic           done_q;
  rx_frame_t      res_q;

  logic       sample;
  logic [2:0] last_bit;

  assign sample   = tick_i && (sc_q == SCW'(LAST));
  assign last_bit = len8_i ? 3'd7 : 3'd6;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sc_q        <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      par_q       <= 1'b0;
      one_q       <= 1'b0;
      fe_q        <= 1'b0;
      stop2_q     <= 1'b0;
      addr_q      <= 1'b0;
      idle_cnt_q  <= '0;
      idle_seen_q <= 1'b0;
      done_q      <= 1'b0;
      res_q       <= '0;
    end else if (soft_rst_i) begin
      st_q        <= ST_IDLE;
      sc_q        <= '0;
      bit_q       <= '0;
      idle_cnt_q  <= '0;
      idle_seen_q <= 1'b0;
      done_q      <= 1'b0;
      res_q       <= '0;
    end else begin
      done_q <= 1'b0;
      // mark-time counter for idle-line addressing
      if (st_q == ST_IDLE && line_i) begin
        if (tick_i && !idle_seen_q) begin
          if (idle_cnt_q == ICW'(IDLE_TICKS - 1)) idle_seen_q <= 1'b1;
          idle_cnt_q <= idle_cnt_q + 1'b1;
        end
      end else begin
        idle_cnt_q <= '0;
      end

      if (st_q != ST_IDLE && st_q != ST_START && tick_i) sc_q <= sc_q + 1'b1;

      unique case (st_q)
        ST_IDLE: begin
          if (tick_i && !line_i) begin
            st_q <= ST_START;
            sc_q <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (sc_q == SCW'(MID)) begin
              sc_q <= '0;
              if (!line_i) begin
                st_q    <= ST_DATA;
                bit_q   <= '0;
                par_q   <= 1'b0;
                one_q   <= 1'b0;
                fe_q    <= 1'b0;
                stop2_q <= 1'b0;
                addr_q  <= 1'b0;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              sc_q <= sc_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sample) begin
            sh_q  <= {line_i, sh_q[7:1]};
            par_q <= par_q ^ line_i;
            one_q <= one_q | line_i;
            bit_q <= bit_q + 1'b1;
            if (bit_q == last_bit)
              st_q <= addr_mode_i ? ST_ADDR : (par_en_i ? ST_PAR : ST_STOP);
          end
        end
        ST_ADDR: begin
          if (sample) begin
            addr_q <= line_i;
            par_q  <= par_q ^ line_i;
            one_q  <= one_q | line_i;
            st_q   <= par_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (sample) begin
            par_q <= par_q ^ line_i;
            one_q <= one_q | line_i;
            st_q  <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (sample) begin
            one_q <= one_q | line_i;
            fe_q  <= fe_q | ~line_i;
            if (two_stop_i && !stop2_q) begin
              stop2_q <= 1'b1;
            end else begin
              st_q        <= ST_IDLE;
              done_q      <= 1'b1;
              idle_seen_q <= 1'b0;
              res_q.data  <= len8_i ? sh_q : {1'b0, sh_q[7:1]};
              res_q.fe    <= fe_q | ~line_i;
              res_q.pe    <= par_en_i && (par_q == par_even_i);
              res_q.brk   <= ~(one_q | line_i);
              res_q.addr  <= addr_mode_i ? addr_q : idle_seen_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign frame_o = res_q;

  a_r13_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r5_break_has_fe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && res_q.brk) |-> res_q.fe);
endmodule

// File: rtl/rx_flags.sv
`timescale 1ns/1ps
module rx_flags
  import mp_uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       done_i,
  input  rx_frame_t  frame_i,
  input  logic       wake_only_i,
  input  logic       err_keep_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       fe_o,
  output logic       pe_o,
  output logic       oe_o,
  output logic       brk_o,
  output logic       wake_o
);
  logic [7:0] data_q;
  logic       ready_q, fe_q, pe_q, oe_q, brk_q, wake_q;
  logic       frm_err, load;

  assign frm_err = frame_i.fe | frame_i.pe | frame_i.brk;
  assign load    = done_i && (err_keep_i || !frm_err) && (!wake_only_i || frame_i.addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      brk_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else if (soft_rst_i) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      brk_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      fe_q    <= (fe_q  & ~rd_i) | (done_i & frame_i.fe);
      pe_q    <= (pe_q  & ~rd_i) | (done_i & frame_i.pe);
      brk_q   <= (brk_q & ~rd_i) | (done_i & frame_i.brk);
      oe_q    <= (oe_q  & ~rd_i) | (load & ready_q & ~rd_i);
      ready_q <= load | (ready_q & ~rd_i);
      wake_q  <= load ? frame_i.addr : (wake_q & ~rd_i);
      if (load) data_q <= frame_i.data;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign fe_o    = fe_q;
  assign pe_o    = pe_q;
  assign oe_o    = oe_q;
  assign brk_o   = brk_q;
  assign wake_o  = wake_q;

  a_r6_overrun_on_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && ready_q && !rd_i && !soft_rst_i) |=> oe_q);

  a_r11_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!ready_q && !fe_q && !pe_q && !oe_q && !brk_q && !wake_q));

  a_r9_data_not_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && wake_only_i && !frame_i.addr && !ready_q) |=> !ready_q);

  a_r10_reject_keeps_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !err_keep_i && frm_err && !soft_rst_i) |=> $stable(data_q));

  a_r12_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!ready_q && !fe_q && !pe_q && !oe_q && !brk_q && !wake_q && data_q == 8'h00));
endmodule

// File: rtl/mp_uart_rx.sv
`timescale 1ns/1ps
module mp_uart_rx
  import mp_uart_rx_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int GLITCH_CYC = 3,
  parameter int IDLE_BITS  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       os_tick_i,
  input  logic       rxd_i,
  input  logic       len8_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       two_stop_i,
  input  logic       addr_bit_mode_i,
  input  logic       wake_only_i,
  input  logic       err_keep_i,
  input  logic       rd_i,
  output logic [7:0] rx_data_o,
  output logic       rx_ready_o,
  output logic       fe_o,
  output logic       pe_o,
  output logic       oe_o,
  output logic       brk_o,
  output logic       rx_err_o,
  output logic       wake_o
);
  logic      line;
  logic      done;
  rx_frame_t frame;

  rx_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_deglitch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .line_o (line)
  );

  rx_frame #(.OS_RATE(OS_RATE), .IDLE_BITS(IDLE_BITS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .tick_i      (os_tick_i),
    .line_i      (line),
    .len8_i      (len8_i),
    .par_en_i    (par_en_i),
    .par_even_i  (par_even_i),
    .two_stop_i  (two_stop_i),
    .addr_mode_i (addr_bit_mode_i),
    .done_o      (done),
    .frame_o     (frame)
  );

  rx_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .done_i      (done),
    .frame_i     (frame),
    .wake_only_i (wake_only_i),
    .err_keep_i  (err_keep_i),
    .rd_i        (rd_i),
    .data_o      (rx_data_o),
    .ready_o     (rx_ready_o),
    .fe_o        (fe_o),
    .pe_o        (pe_o),
    .oe_o        (oe_o),
    .brk_o       (brk_o),
    .wake_o      (wake_o)
  );

  assign rx_err_o = fe_o | pe_o | oe_o | brk_o;
endmodule

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
  localparam int IDLE_T = 176;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic len8 = 1'b1, par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic abit_mode = 1'b1, wake_only = 1'b0, err_keep = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, fe, pe, oe, brk, rx_err, wake;

  always #2.5 clk = ~clk;

  mp_uart_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .os_tick_i(1'b1), .rxd_i(rxd),
    .len8_i(len8), .par_en_i(par_en), .par_even_i(par_even), .two_stop_i(two_stop),
    .addr_bit_mode_i(abit_mode), .wake_only_i(wake_only), .err_keep_i(err_keep), .rd_i(rd),
    .rx_data_o(rx_data), .rx_ready_o(rx_ready), .fe_o(fe), .pe_o(pe), .oe_o(oe),
    .brk_o(brk), .rx_err_o(rx_err), .wake_o(wake)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  // reference model: expected state as of each edge
  typedef struct {int at; logic [7:0] d; bit fe; bit pe; bit brk; bit addr;} ev_t;
  ev_t evq[$];
  int  cyc = 0;
  int  last_s = -100000;
  logic [7:0] e_data = 0;
  bit e_rdy = 0, e_fe = 0, e_pe = 0, e_oe = 0, e_brk = 0, e_wake = 0;
  bit cmp_on = 0;
  ev_t cur;
  bit  have;

  always @(posedge clk) begin
    cyc = cyc + 1;
    cmp_on = 1;
    if (!rst_ni || soft_rst) begin
      e_data = 0; e_rdy = 0; e_fe = 0; e_pe = 0; e_oe = 0; e_brk = 0; e_wake = 0;
      if (soft_rst) last_s = cyc;
    end else begin
      have = 0;
      if (evq.size() != 0 && evq[0].at == cyc) begin
        cur = evq.pop_front();
        have = 1;
      end
      if (rd) begin
        e_rdy = 0; e_fe = 0; e_pe = 0; e_oe = 0; e_brk = 0; e_wake = 0;
      end
      if (have) begin
        e_fe  = e_fe  | cur.fe;
        e_pe  = e_pe  | cur.pe;
        e_brk = e_brk | cur.brk;
        if ((err_keep || !(cur.fe || cur.pe || cur.brk)) && (!wake_only || cur.addr)) begin
          if (e_rdy) e_oe = 1;
          e_rdy  = 1;
          e_data = cur.d;
          e_wake = cur.addr;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 data",   rx_data,  e_data);
      chk("R13 ready", {7'd0, rx_ready}, {7'd0, e_rdy});
      chk("R4 fe",     {7'd0, fe},  {7'd0, e_fe});
      chk("R3 pe",     {7'd0, pe},  {7'd0, e_pe});
      chk("R6 oe",     {7'd0, oe},  {7'd0, e_oe});
      chk("R5 brk",    {7'd0, brk}, {7'd0, e_brk});
      chk("R8 wake",   {7'd0, wake}, {7'd0, e_wake});
      chk("R11 err",   {7'd0, rx_err}, {7'd0, (e_fe | e_pe | e_oe | e_brk)});
    end
  end

  task automatic send(input logic [7:0] d, input bit abit, input bit bad_par,
                      input bit stop_low, input int gap);
    bit b[$];
    int k, n, ones, nd;
    bit pb, allz;
    ev_t ev;
    nd = len8 ? 8 : 7;
    for (int i = 0; i < nd; i++) b.push_back(d[i]);
    if (abit_mode) b.push_back(abit);
    if (par_en) begin
      ones = 0;
      foreach (b[i]) ones += int'(b[i]);
      pb = par_even ? bit'(ones % 2) : !bit'(ones % 2);
      if (bad_par) pb = !pb;
      b.push_back(pb);
    end
    b.push_back(!stop_low);
    if (two_stop) b.push_back(1'b1);
    n = b.size();
    allz = 1;
    foreach (b[i]) if (b[i]) allz = 0;
    ev.d   = len8 ? d : {1'b0, d[6:0]};
    ev.fe  = stop_low;
    ev.pe  = par_en && bad_par;
    ev.brk = allz;
    @(negedge clk);
    k = cyc + 1;
    ev.addr = abit_mode ? abit : ((k + 4 - last_s) >= IDLE_T);
    ev.at   = k + 14 + 16 * n;   // R13
    last_s  = k + 13 + 16 * n;
    evq.push_back(ev);
    rxd = 1'b0;
    repeat (15) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (16 * gap) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {7'd0, rx_ready}, 8'd0);
    chk("R12 reset data", rx_data, 8'd0);
    rst_ni = 1'b1;
    repeat (300) @(negedge clk);

    // address-bit mode, 8 bits, no parity
    send(8'hA5, 1'b1, 0, 0, 3);
    chk("R1 byte lsb first", rx_data, 8'hA5);
    chk("R8 address wake", {7'd0, wake}, 8'd1);
    do_read();
    chk("R11 read clears ready", {7'd0, rx_ready}, 8'd0);
    chk("R11 read clears wake", {7'd0, wake}, 8'd0);
    chk("R11 data kept", rx_data, 8'hA5);
    send(8'h3C, 1'b0, 0, 0, 3);
    chk("R8 data wake", {7'd0, wake}, 8'd0);
    send(8'h5A, 1'b0, 0, 0, 3);
    chk("R6 overrun", {7'd0, oe}, 8'd1);
    chk("R11 combined err", {7'd0, rx_err}, 8'd1);
    do_read();
    chk("R11 oe cleared", {7'd0, oe}, 8'd0);

    // 7-bit characters
    len8 = 1'b0;
    send(8'hFF, 1'b0, 0, 0, 3);
    chk("R1 seven bit msb", rx_data, 8'h7F);
    do_read();

    // odd parity, rejecting errors
    par_en = 1'b1; par_even = 1'b0; len8 = 1'b1;
    send(8'h55, 1'b1, 0, 0, 3);
    chk("R3 odd good", {7'd0, pe}, 8'd0);
    chk("R3 odd data", rx_data, 8'h55);
    do_read();
    send(8'h12, 1'b1, 1, 0, 3);
    chk("R3 odd bad", {7'd0, pe}, 8'd1);
    chk("R10 rejected ready", {7'd0, rx_ready}, 8'd0);
    chk("R10 rejected data", rx_data, 8'h55);
    do_read();
    // even parity, keeping errors
    par_even = 1'b1; err_keep = 1'b1;
    send(8'h81, 1'b0, 1, 0, 3);
    chk("R3 even bad", {7'd0, pe}, 8'd1);
    chk("R10 kept data", rx_data, 8'h81);
    chk("R10 kept ready", {7'd0, rx_ready}, 8'd1);
    do_read();
    send(8'h07, 1'b0, 0, 0, 3);
    chk("R3 even good", {7'd0, pe}, 8'd0);
    do_read();

    // two stop bits, framing
    par_en = 1'b0; two_stop = 1'b1;
    send(8'hC3, 1'b0, 0, 0, 3);
    chk("R4 two stop good", {7'd0, fe}, 8'd0);
    chk("R1 two stop data", rx_data, 8'hC3);
    do_read();
    send(8'h44, 1'b0, 0, 1, 4);
    chk("R4 stop low", {7'd0, fe}, 8'd1);
    do_read();
    two_stop = 1'b0;

    // break
    send(8'h00, 1'b0, 0, 1, 4);
    chk("R5 break", {7'd0, brk}, 8'd1);
    chk("R4 break fe", {7'd0, fe}, 8'd1);
    do_read();
    send(8'h00, 1'b1, 0, 0, 3);
    chk("R5 no break", {7'd0, brk}, 8'd0);
    do_read();

    // wake-only filter
    wake_only = 1'b1; err_keep = 1'b0;
    send(8'h66, 1'b0, 0, 0, 3);
    chk("R9 data dropped", {7'd0, rx_ready}, 8'd0);
    chk("R9 data buf", rx_data, 8'h00);
    send(8'h99, 1'b1, 0, 0, 3);
    chk("R9 addr loaded", rx_data, 8'h99);
    chk("R9 addr ready", {7'd0, rx_ready}, 8'd1);
    do_read();
    wake_only = 1'b0;

    // glitch
    @(negedge clk); rxd = 1'b0;
    @(negedge clk);
    @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R2 glitch ready", {7'd0, rx_ready}, 8'd0);
    chk("R2 glitch data", rx_data, 8'h99);

    // soft reset
    send(8'h5E, 1'b1, 0, 0, 3);
    send(8'h5F, 1'b1, 0, 0, 3);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R12 soft ready", {7'd0, rx_ready}, 8'd0);
    chk("R12 soft oe", {7'd0, oe}, 8'd0);
    chk("R12 soft data", rx_data, 8'd0);
    repeat (300) @(negedge clk);

    // idle-line addressing
    abit_mode = 1'b0;
    send(8'h11, 1'b0, 0, 0, 2);
    chk("R7 first after idle", {7'd0, wake}, 8'd1);
    do_read();
    send(8'h22, 1'b0, 0, 0, 12);
    chk("R7 short gap data", {7'd0, wake}, 8'd0);
    do_read();
    send(8'h33, 1'b0, 0, 0, 10);
    chk("R7 long gap address", {7'd0, wake}, 8'd1);
    do_read();
    send(8'h44, 1'b0, 0, 0, 3);
    chk("R7 ten bit gap data", {7'd0, wake}, 8'd0);
    chk("R7 data value", rx_data, 8'h44);
    do_read();
    wake_only = 1'b1;
    send(8'h77, 1'b0, 0, 0, 3);
    chk("R9 idle data dropped", {7'd0, rx_ready}, 8'd0);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule